// File: doc/BRIEF.md
# Dual-Modulus Swallow-Counter Divider

This block is the digital half of a programmable frequency divider built around an external dual-modulus prescaler that divides a fast input by either 8 or 9. The block runs on the prescaler output, counts its periods, and drives the modulus-select line back to the prescaler. Over one division cycle the prescaler is held at divide-by-9 for the first A of its output periods and at divide-by-8 for the rest, so the fast input is divided by 8·M + A in total. One output pulse, exactly one prescaler period wide (8 fast-input cycles when the prescaler is at divide-by-8), marks the end of each division cycle.

The division ratio arrives as a 14-bit parallel word: the low 3 bits hold A (the swallow count) and the upper 11 bits hold M (the main count). The word is not latched at the block edge. It is read directly on the clock edge that closes a division cycle, so a new word takes effect only from the next cycle boundary. A word that cannot be divided correctly is flagged when it is loaded. Such a word has M < A, or gives a total ratio below 56, the smallest ratio from which every integer ratio can be reached with a modulus of 8. The counters keep running after such a word is loaded.

Top module: `swallow_divider`

## Requirements
- R1: Ratio word bits [2:0] are A and bits [13:3] are M. For a word with M ≥ A and 8·M + A ≥ 56, each division cycle lasts M prescaler periods, and the weighted count (9 per period with `mod_sel` high, 8 per period with it low) over the cycle equals 8·M + A.
- R2: In each division cycle, `mod_sel` (1 selects divide-by-9, 0 selects divide-by-8) is high for the first A prescaler periods and low for the remaining M − A periods. It only rises on the first period of a division cycle.
- R3: `div_pulse` is high during the last prescaler period of each division cycle and low in every other period. For M = 1 it is high in every period.
- R4: The ratio word is read on the clock edge that ends a division cycle. A change made part-way through a cycle leaves that cycle's length unchanged and sets the length of the next cycle.
- R5: A synchronous reset (`rst` high at a clock edge) forces `div_pulse`, `mod_sel` and `ratio_bad` low after that edge. The first division cycle begins at the first edge after `rst` is released, so the first pulse appears in the M-th period after release.
- R6: `ratio_bad` is updated each time a word is loaded. It goes high when the loaded word has M < A or 8·M + A < 56, and it returns low when a legal word is loaded.
- R7: An illegal word never stops the divider. With M < A, `mod_sel` stays high for the whole cycle and the cycle still lasts M periods. M = 0 behaves as a count of 2048 periods.
- R8: The two range limits, ratio 56 (M = 7, A = 0) and ratio 16383 (M = 2047, A = 7), divide correctly with `ratio_bad` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous reset, active high |
| ratio_word | input | 14 | Division ratio: bits [2:0] A, bits [13:3] M |
| mod_sel | output | 1 | Prescaler modulus select, 1 = divide-by-9 |
| div_pulse | output | 1 | One prescaler period wide pulse at the end of each division cycle |
| ratio_bad | output | 1 | Loaded ratio word is outside the legal range |

## Verification
The bench contains a behavioural prescaler model. It weights each sampled period by 9 or 8 according to `mod_sel`, so it measures the true fast-input division between pulses, at both range limits and at several ratios in between. A design that swapped the A and M fields, or ran the swallow count one period short or long, would give a weighted count that differs by one or more. The bench changes the word in the middle of a cycle: a design that used the new word at once would give a mixed length for that cycle. The bench also loads illegal words (M < A, M = 1, M = 0, a ratio below 56). It checks that `ratio_bad` rises and falls on the loads and that pulses keep arriving, so a design that stalled on a zero or underflowed count would time out.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

   typedef enum logic {
      MOD_LOW  = 1'b0,
      MOD_HIGH = 1'b1
   } modsel_e;

   function automatic int unsigned total_ratio(input int unsigned m,
                                               input int unsigned a,
                                               input int unsigned n);
      return m * n + a;
   endfunction

   function automatic int unsigned min_steppable(input int unsigned n);
      return n * (n - 1);
   endfunction

endpackage

// File: rtl/swdiv_main_cnt.sv
module swdiv_main_cnt #(
   parameter int M_W = 11
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [M_W-1:0] m_load,
   output logic           reload,
   output logic           primed,
   output logic [M_W-1:0] m_cnt
);

   localparam logic [M_W-1:0] M_ONE  = M_W'(1);
   localparam logic [M_W-1:0] M_ZERO = '0;

   assign reload = !primed || (m_cnt == M_ZERO);

   always_ff @(posedge clk) begin
      if (rst) begin
         m_cnt  <= M_ZERO;
         primed <= 1'b0;
      end else if (reload) begin
         m_cnt  <= m_load - M_ONE;
         primed <= 1'b1;
      end else begin
         m_cnt  <= m_cnt - M_ONE;
      end
   end

endmodule

// File: rtl/swdiv_swallow_cnt.sv
module swdiv_swallow_cnt #(
   parameter int A_W = 3
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           reload,
   input  logic [A_W-1:0] a_load,
   output swdiv_pkg::modsel_e modsel
);

   localparam logic [A_W-1:0] A_ONE  = A_W'(1);
   localparam logic [A_W-1:0] A_ZERO = '0;

   logic [A_W-1:0] a_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         a_cnt <= A_ZERO;
      end else if (reload) begin
         a_cnt <= a_load;
      end else if (a_cnt != A_ZERO) begin
         a_cnt <= a_cnt - A_ONE;
      end
   end

   assign modsel = (a_cnt != A_ZERO) ? swdiv_pkg::MOD_HIGH : swdiv_pkg::MOD_LOW;

endmodule

// File: rtl/swdiv_range_chk.sv
module swdiv_range_chk #(
   parameter int M_W       = 11,
   parameter int A_W       = 3,
   parameter int PRE_MOD   = 8,
   parameter int MIN_RATIO = 56
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           reload,
   input  logic [M_W-1:0] m_load,
   input  logic [A_W-1:0] a_load,
   output logic           bad
);

   logic        swallow_excess;
   logic        below_floor;
   int unsigned ratio_v;

   always_comb begin
      ratio_v        = swdiv_pkg::total_ratio(32'(m_load), 32'(a_load), PRE_MOD);
      swallow_excess = 32'(m_load) < 32'(a_load);
      below_floor    = ratio_v < MIN_RATIO;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         bad <= 1'b0;
      end else if (reload) begin
         bad <= swallow_excess || below_floor;
      end
   end

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
   parameter int PRE_MOD = 8,
   parameter int M_W     = 11
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic [$clog2(PRE_MOD)+M_W-1:0]        ratio_word,
   output logic                                  mod_sel,
   output logic                                  div_pulse,
   output logic                                  ratio_bad
);

   localparam int A_W       = $clog2(PRE_MOD);
   localparam int WORD_W    = A_W + M_W;
   localparam int MIN_RATIO = int'(swdiv_pkg::min_steppable(PRE_MOD));

   generate
      if ((1 << A_W) != PRE_MOD) begin : g_bad_modulus
         $error("swallow_divider: PRE_MOD must be a power of two");
      end
      if (M_W < 2) begin : g_bad_mwidth
         $error("swallow_divider: M_W must be at least 2");
      end
   endgenerate

   logic [M_W-1:0]      m_field;
   logic [A_W-1:0]      a_field;
   logic                reload_w;
   logic                primed_w;
   logic [M_W-1:0]      m_cnt_w;
   swdiv_pkg::modsel_e  modsel_w;

   assign a_field = ratio_word[A_W-1:0];
   assign m_field = ratio_word[WORD_W-1:A_W];

   swdiv_main_cnt #(.M_W(M_W)) main_i (
      .clk    (clk),
      .rst    (rst),
      .m_load (m_field),
      .reload (reload_w),
      .primed (primed_w),
      .m_cnt  (m_cnt_w)
   );

   swdiv_swallow_cnt #(.A_W(A_W)) swallow_i (
      .clk    (clk),
      .rst    (rst),
      .reload (reload_w),
      .a_load (a_field),
      .modsel (modsel_w)
   );

   swdiv_range_chk #(
      .M_W       (M_W),
      .A_W       (A_W),
      .PRE_MOD   (PRE_MOD),
      .MIN_RATIO (MIN_RATIO)
   ) range_i (
      .clk    (clk),
      .rst    (rst),
      .reload (reload_w),
      .m_load (m_field),
      .a_load (a_field),
      .bad    (ratio_bad)
   );

   assign mod_sel   = (modsel_w == swdiv_pkg::MOD_HIGH);
   assign div_pulse = primed_w && (m_cnt_w == '0);

endmodule

// File: rtl/swdiv_checker.sv
module swdiv_checker #(
   parameter int PRE_MOD = 8,
   parameter int M_W     = 11,
   parameter int A_W     = 3
) (
   input logic                 clk,
   input logic                 rst,
   input logic [A_W+M_W-1:0]   ratio_word,
   input logic                 mod_sel,
   input logic                 div_pulse,
   input logic                 ratio_bad,
   input logic                 primed,
   input logic [M_W-1:0]       m_cnt
);

   localparam int MIN_R = PRE_MOD * (PRE_MOD - 1);

   int  m_f;
   int  a_f;
   logic word_illegal;

   always_comb begin
      m_f          = int'(ratio_word[A_W+M_W-1:A_W]);
      a_f          = int'(ratio_word[A_W-1:0]);
      word_illegal = (m_f < a_f) || ((m_f * PRE_MOD + a_f) < MIN_R);
   end

   // R5: reset silences every output
   p_reset_quiet_r5: assert property (@(posedge clk)
      rst |=> (!div_pulse && !mod_sel && !ratio_bad));

   // R3: pulse is one period wide unless M is one
   p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
      (div_pulse && (m_f != 1)) |=> !div_pulse);

   // R2: divide-by-9 only begins at a cycle boundary
   p_modsel_rise_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(mod_sel) |-> ($past(div_pulse) || !$past(primed)));

   // R1: main count steps down by one per period
   p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
      (primed && (m_cnt != '0)) |=> (m_cnt == $past(m_cnt) - 1'b1));

   // R6: flag follows the word loaded at each boundary
   p_flag_load_r6: assert property (@(posedge clk) disable iff (rst)
      (div_pulse || !primed) |=> (ratio_bad == $past(word_illegal)));

endmodule

bind swallow_divider swdiv_checker #(
   .PRE_MOD (PRE_MOD),
   .M_W     (M_W),
   .A_W     (A_W)
) chk_i (
   .clk        (clk),
   .rst        (rst),
   .ratio_word (ratio_word),
   .mod_sel    (mod_sel),
   .div_pulse  (div_pulse),
   .ratio_bad  (ratio_bad),
   .primed     (primed_w),
   .m_cnt      (m_cnt_w)
);

// File: tb/swallow_divider_tb_top.sv
module swallow_divider_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [13:0] ratio_word = '0;
   logic        mod_sel;
   logic        div_pulse;
   logic        ratio_bad;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   swallow_divider dut_i (
      .clk        (clk),
      .rst        (rst),
      .ratio_word (ratio_word),
      .mod_sel    (mod_sel),
      .div_pulse  (div_pulse),
      .ratio_bad  (ratio_bad)
   );

   localparam int NV = 8;
   localparam int VM [NV] = '{7, 7, 100, 9, 12, 2047, 1000, 31};
   localparam int VA [NV] = '{0, 7, 3,   5, 0,  7,    6,    1};

   function automatic logic [13:0] mk(input int m, input int a);
      logic [13:0] w;
      w[13:3] = m[10:0];
      w[2:0]  = a[2:0];
      return w;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // prescaler model: each sampled period spans 9 or 8 fast cycles
   task automatic measure(output int sum, output int hi, output int len);
      int guard = 0;
      sum = 0; hi = 0; len = 0;
      do begin
         @(negedge clk);
         len++;
         sum += mod_sel ? 9 : 8;
         hi  += mod_sel ? 1 : 0;
         guard++;
      end while (!div_pulse && guard < 5000);
   endtask

   task automatic wait_pulse();
      int guard = 0;
      while (!div_pulse && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic run_word(input int m, input int a, input int exp_ratio, input int exp_hi,
                           input int exp_len, input bit exp_flag, input string req);
      int sum, hi, len;
      @(negedge clk);
      ratio_word = mk(m, a);
      wait_pulse();
      measure(sum, hi, len);
      chk(sum == exp_ratio, {req, " weighted ratio"}, sum, exp_ratio);
      chk(hi == exp_hi, {req, " R2 divide-by-9 periods"}, hi, exp_hi);
      chk(len == exp_len, {req, " cycle length"}, len, exp_len);
      chk(ratio_bad == exp_flag, {req, " R6 flag"}, int'(ratio_bad), int'(exp_flag));
      if (exp_len > 1) begin
         @(negedge clk);
         chk(!div_pulse, {req, " R3 pulse one period"}, int'(div_pulse), 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int n, hi, sum, len;
      ratio_word = mk(7, 2);
      repeat (3) @(negedge clk);
      // R5: reset state
      chk(!div_pulse && !mod_sel && !ratio_bad, "R5 reset outputs",
          int'({div_pulse, mod_sel, ratio_bad}), 0);
      rst = 1'b0;
      n = 0; hi = 0; sum = 0;
      do begin
         @(negedge clk);
         n++;
         hi  += mod_sel ? 1 : 0;
         sum += mod_sel ? 9 : 8;
      end while (!div_pulse && n < 100);
      chk(n == 7, "R5 first pulse period", n, 7);
      chk(sum == 58, "R1 first cycle ratio", sum, 58);
      chk(hi == 2, "R2 first cycle swallow", hi, 2);

      // R1/R8 table walk
      for (int i = 0; i < NV; i++) begin
         run_word(VM[i], VA[i], VM[i] * 8 + VA[i], VA[i], VM[i], 1'b0,
                  (i == 0 || i == 5) ? "R8" : "R1");
      end

      // R4: change mid-cycle
      run_word(20, 4, 164, 4, 20, 1'b0, "R4 setup");
      wait_pulse();
      sum = 0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         sum += mod_sel ? 9 : 8;
      end
      ratio_word = mk(10, 1);
      do begin
         @(negedge clk);
         sum += mod_sel ? 9 : 8;
      end while (!div_pulse);
      chk(sum == 164, "R4 current cycle keeps old ratio", sum, 164);
      measure(sum, hi, len);
      chk(sum == 81, "R4 next cycle uses new ratio", sum, 81);

      // R7/R6: illegal words keep running
      run_word(3, 5, 27, 3, 3, 1'b1, "R7 M<A");
      run_word(5, 2, 42, 2, 5, 1'b1, "R6 below floor");
      run_word(0, 0, 16384, 0, 2048, 1'b1, "R7 M zero");
      run_word(1, 0, 8, 0, 1, 1'b1, "R7 M one");
      @(negedge clk);
      chk(div_pulse, "R3 continuous pulse at M one", int'(div_pulse), 1);

      // R5: synchronous reset mid-run
      rst = 1'b1;
      @(negedge clk);
      chk(!div_pulse && !mod_sel && !ratio_bad, "R5 mid-run reset",
          int'({div_pulse, mod_sel, ratio_bad}), 0);
      ratio_word = mk(7, 0);
      rst = 1'b0;

      run_word(7, 0, 56, 0, 7, 1'b0, "R6 flag clears");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule